// File: doc/BRIEF.md
# Mode-Aware Watchdog Timer

This block is a watchdog that counts on a slow clock. A base counter overflows at a fixed rate. A selectable postscaler counts those overflows, and when it runs out the watchdog has expired. What an expiry does depends on what the core is doing at that moment. If the core is running code, the block raises a one-cycle reset request. If the core is idle or asleep, it raises a one-cycle wake request and no reset.

Software restarts the timing with a clear-watchdog instruction strobe. The sleep instruction strobe also restarts it, so a sleep period always begins from a fresh count. Both strobes zero the base counter and the postscaler. A sticky timeout flag records that any expiry happened. An acknowledge input clears the flag, and so does reset. When the enable is low, both counters are held at zero and no request is issued.

Top module: `wdt_mode_aware`

## Requirements
- R1: After reset (`rst_n` low), `wake_o`, `rst_req_o` and `to_flag_o` are 0.
- R2: With `wdt_en` high and no strobes, an expiry occurs every 2^BASE_W × 2^`ps_sel` clock cycles. `ps_sel` is a 4-bit unsigned value, so the postscaler ratio runs from 1:1 (value 0) to 1:32768 (value 15). The request appears on the cycle that follows the expiry, and the first request comes exactly that many cycles after the last clear.
- R3: A `clrwdt_i` strobe sets both the base counter and the postscaler to zero, and a full period restarts from that strobe.
- R4: A `sleep_i` strobe also sets both counters to zero, with the same restart as R3.
- R5: An expiry while `core_run` is 0 gives a one-cycle `wake_o` pulse and no `rst_req_o`.
- R6: An expiry while `core_run` is 1 gives a one-cycle `rst_req_o` pulse and no `wake_o`.
- R7: Every expiry sets `to_flag_o`. The flag stays high until `flag_ack` is sampled high or the block is reset. If an expiry and an acknowledge happen in the same cycle, the flag is set.
- R8: If a clear strobe (`clrwdt_i` or `sleep_i`) happens in the same cycle as an expiry, the clear wins: no pulse is issued and the flag is left as it was.
- R9: While `wdt_en` is low, both counters stay at zero and no pulse is issued. After the enable returns, a full period is counted again.
- R10: `wake_o` and `rst_req_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wdt_en | input | 1 | Watchdog enable |
| ps_sel | input | 4 | Postscaler select, ratio 2^ps_sel |
| clrwdt_i | input | 1 | Clear-watchdog instruction strobe |
| sleep_i | input | 1 | Sleep instruction strobe |
| core_run | input | 1 | 1 = core executing, 0 = idle or sleep |
| flag_ack | input | 1 | Clears the timeout flag |
| wake_o | output | 1 | Wake request pulse |
| rst_req_o | output | 1 | Reset request pulse |
| to_flag_o | output | 1 | Sticky timeout flag |

## Verification
The bench measures the distance from a clear to the request for several postscaler settings. A design with an off-by-one in its overflow or in its limit would show up as a request that comes one cycle early or late. It places a clear strobe exactly on the expiry cycle. A design where the expiry wins would then issue a stray wake and set the flag. It drops the enable partway through a count and then checks for a full period. A design that only paused its counters would expire early. Random stretches that toggle the run state and the acknowledge check that a request is routed by the current mode and never to both outputs. A wrong routing would reset a core that was only sleeping.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W  = 4;
  localparam int POST_W = (1 << SEL_W) - 1;

  // terminal postscaler value for a ratio of 2^sel
  function automatic logic [POST_W-1:0] post_limit(input logic [SEL_W-1:0] sel);
    logic [POST_W:0] one_hot;
    one_hot = (POST_W+1)'(1) << sel;
    return POST_W'(one_hot - 1'b1);
  endfunction

  // base counter terminal value
  function automatic logic [31:0] base_max(input int width);
    return (32'd1 << width) - 32'd1;
  endfunction
endpackage

// File: rtl/wdt_base_cnt.sv
module wdt_base_cnt #(
  parameter int BASE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  output logic [BASE_W-1:0] cnt_q,
  output logic              tick
);
  import wdt_pkg::*;
  localparam logic [BASE_W-1:0] TOP = BASE_W'(base_max(BASE_W));

  assign tick = en && !clr && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || clr) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler #(
  parameter int SEL_W  = 4,
  parameter int POST_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic              tick,
  input  logic [SEL_W-1:0]  sel,
  output logic [POST_W-1:0] post_q,
  output logic              expire
);
  import wdt_pkg::*;
  logic [POST_W-1:0] limit;

  assign limit  = post_limit(sel);
  assign expire = tick && (post_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || clr) post_q <= '0;
    else if (expire)          post_q <= '0;
    else if (tick)            post_q <= post_q + 1'b1;
  end
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic core_run,
  input  logic ack,
  output logic wake_o,
  output logic rst_req_o,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_o    <= 1'b0;
      rst_req_o <= 1'b0;
      flag_o    <= 1'b0;
    end else begin
      wake_o    <= expire && !core_run;
      rst_req_o <= expire && core_run;
      if (expire)   flag_o <= 1'b1;
      else if (ack) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_mode_aware.sv
module wdt_mode_aware #(
  parameter int BASE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdt_en,
  input  logic [3:0] ps_sel,
  input  logic       clrwdt_i,
  input  logic       sleep_i,
  input  logic       core_run,
  input  logic       flag_ack,
  output logic       wake_o,
  output logic       rst_req_o,
  output logic       to_flag_o
);
  import wdt_pkg::*;

  logic              clr_w;
  logic              tick_w;
  logic              expiry_w;
  logic [BASE_W-1:0] base_q;
  logic [POST_W-1:0] post_q;

  assign clr_w = clrwdt_i || sleep_i;

  wdt_base_cnt #(.BASE_W(BASE_W)) u_base (
    .clk(clk), .rst_n(rst_n), .en(wdt_en), .clr(clr_w),
    .cnt_q(base_q), .tick(tick_w)
  );

  wdt_postscaler #(.SEL_W(SEL_W), .POST_W(POST_W)) u_post (
    .clk(clk), .rst_n(rst_n), .en(wdt_en), .clr(clr_w),
    .tick(tick_w), .sel(ps_sel), .post_q(post_q), .expire(expiry_w)
  );

  wdt_event u_evt (
    .clk(clk), .rst_n(rst_n), .expire(expiry_w), .core_run(core_run),
    .ack(flag_ack), .wake_o(wake_o), .rst_req_o(rst_req_o), .flag_o(to_flag_o)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int BASE_W = 4,
  parameter int POST_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wdt_en,
  input logic              core_run,
  input logic              flag_ack,
  input logic              clr_w,
  input logic              expiry_w,
  input logic [BASE_W-1:0] base_q,
  input logic [POST_W-1:0] post_q,
  input logic              wake_o,
  input logic              rst_req_o,
  input logic              to_flag_o
);
  // R5
  wake_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expiry_w && !core_run |=> wake_o && !rst_req_o);
  // R6
  reset_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expiry_w && core_run |=> rst_req_o && !wake_o);
  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_o && rst_req_o));
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag_o && !flag_ack |=> to_flag_o);
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expiry_w |=> to_flag_o);
  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> !wake_o && !rst_req_o);
  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> base_q == '0 && post_q == '0);
  // R9
  disable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> base_q == '0 && post_q == '0 && !wake_o && !rst_req_o);
endmodule

bind wdt_mode_aware wdt_chk #(.BASE_W(BASE_W), .POST_W(POST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .core_run(core_run),
  .flag_ack(flag_ack), .clr_w(clr_w), .expiry_w(expiry_w),
  .base_q(base_q), .post_q(post_q), .wake_o(wake_o),
  .rst_req_o(rst_req_o), .to_flag_o(to_flag_o)
);

// File: tb/tb_wdt_mode_aware.sv
module tb_wdt_mode_aware;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_en = 1'b0;
  logic [3:0] ps_sel = 4'd0;
  logic clrwdt_i = 1'b0, sleep_i = 1'b0, core_run = 1'b0, flag_ack = 1'b0;
  logic wake_o, rst_req_o, to_flag_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // bench reference state
  int  m_cnt = 0;
  bit  m_wake = 0, m_rst = 0, m_flag = 0;

  wdt_mode_aware #(.BASE_W(BASE_W)) dut (
    .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .ps_sel(ps_sel),
    .clrwdt_i(clrwdt_i), .sleep_i(sleep_i), .core_run(core_run),
    .flag_ack(flag_ack), .wake_o(wake_o), .rst_req_o(rst_req_o),
    .to_flag_o(to_flag_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int period_of(input int sel);
    return 16 * (1 << sel);
  endfunction

  // the reference counts enabled cycles since the last clear as one number
  always @(posedge clk) begin
    bit hit;
    if (!rst_n) begin
      m_cnt = 0; m_wake = 0; m_rst = 0; m_flag = 0;
    end else begin
      hit = 0;
      if (!wdt_en || clrwdt_i || sleep_i) m_cnt = 0;
      else if (m_cnt == period_of(ps_sel) - 1) begin hit = 1; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
      m_wake = hit && !core_run;
      m_rst  = hit && core_run;
      if (hit) m_flag = 1;
      else if (flag_ack) m_flag = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    check("R5 wake_o", wake_o, m_wake);
    check("R6 rst_req_o", rst_req_o, m_rst);
    check("R7 to_flag_o", to_flag_o, m_flag);
    check("R10 exclusive", wake_o && rst_req_o, 0);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); cmp_model();
  endtask

  // clear via chosen strobe, then count edges to the first request
  task automatic measure(input string tag, input bit use_sleep, input int exp);
    int n = 0;
    if (use_sleep) sleep_i = 1; else clrwdt_i = 1;
    step();
    sleep_i = 0; clrwdt_i = 0;
    while (!(wake_o || rst_req_o) && n < 5000) begin step(); n++; end
    check(tag, n, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 wake_o", wake_o, 0);
    check("R1 rst_req_o", rst_req_o, 0);
    check("R1 to_flag_o", to_flag_o, 0);
    rst_n = 1; wdt_en = 1; core_run = 0;

    // R2 several ratios, sleeping core
    for (int s = 0; s < 4; s++) begin
      ps_sel = 4'(s);
      measure("R2 period", 0, period_of(s));
      check("R5 wake", wake_o, 1);
      step();
      check("R5 one cycle", wake_o, 0);
    end

    // R6 running core gets reset request
    core_run = 1; ps_sel = 4'd1;
    measure("R6 period", 0, period_of(1));
    check("R6 rst", rst_req_o, 1);
    check("R6 no wake", wake_o, 0);

    // R7 ack clears the flag
    flag_ack = 1; step(); flag_ack = 0;
    check("R7 ack clears", to_flag_o, 0);

    // R3 clear near expiry restarts timing
    core_run = 0; ps_sel = 4'd0;
    measure("R3 restart", 0, 16);
    repeat (14) step();
    measure("R3 clear late", 0, 16);
    // R4 sleep strobe restarts as well
    repeat (10) step();
    measure("R4 sleep restart", 1, 16);

    // R8 clear on the exact expiry cycle
    flag_ack = 1; step(); flag_ack = 0;
    clrwdt_i = 1; step(); clrwdt_i = 0;
    repeat (15) step();
    clrwdt_i = 1; step(); clrwdt_i = 0;
    check("R8 no wake", wake_o, 0);
    check("R8 no flag", to_flag_o, 0);

    // R9 enable low mid-count, then a full period
    repeat (7) step();
    wdt_en = 0;
    repeat (40) begin
      step();
      check("R9 quiet", wake_o || rst_req_o, 0);
    end
    wdt_en = 1;
    begin
      int n = 0;
      while (!(wake_o || rst_req_o) && n < 5000) begin step(); n++; end
      check("R9 full period", n, 16);
    end

    // random stretch, sel only changes with a clear
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4000; i++) begin
      bit c, sl;
      c  = ($urandom % 40) == 0;
      sl = ($urandom % 60) == 0;
      clrwdt_i = c; sleep_i = sl;
      if (c || sl) ps_sel = 4'($urandom % 3);
      core_run = ($urandom % 4) != 0 ? core_run : ~core_run;
      flag_ack = ($urandom % 8) == 0;
      wdt_en   = ($urandom % 50) != 0;
      if (!wdt_en) ps_sel = 4'($urandom % 3);
      step();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule